// File: doc/BRIEF.md
# Multi-Width Integer Execute Unit

This block is the integer datapath of a 64-bit execute stage. Each cycle it takes an operation code and two operands and returns one 64-bit result. The second operand is either a register value or an immediate. The block handles add, subtract, multiply and three kinds of shift at four widths (8, 16, 32 and 64 bits). It also handles full-width bitwise AND, OR and XOR, a three-way compare in signed and unsigned forms, bitwise complement, logical NOT, and sign extension from a narrow field.

The operation is combinational. Its result goes through a single output register, so every result appears one cycle after its inputs. Arithmetic and shifts wrap at the selected width, and the bits above that width read as zero. The three-way compare returns all ones for "less", zero for "equal" and one for "greater", with no separate flag outputs. Writing the register file is left to the surrounding pipeline.

Top module: `int_exec_unit`

## Requirements
- R1: Add (kind 0) and subtract (kind 1) wrap modulo 2^W at the width W selected by the width code. Operand bits above W are ignored, and result bits above W are zero.
- R2: Multiply (kind 2) returns the low W bits of the product, zero-extended to 64 bits.
- R3: Left shift (kind 3) shifts the low W bits of the first operand by the second operand modulo W. The result is truncated to W bits and zero-extended.
- R4: Logical right shift (kind 4) shifts zeros into bit W-1, with the amount taken modulo W, and zero-extends the result.
- R5: Arithmetic right shift (kind 5) copies bit W-1 of the first operand into the vacated positions, with the amount taken modulo W. Bits above W are zero.
- R6: AND (kind 6), OR (kind 7) and XOR (kind 8) always act on all 64 bits, whatever the width code.
- R7: Unsigned compare (kind 9) and signed compare (kind 10) return all ones when the first operand is less than the second, 0 when the two are equal, and 1 when it is greater.
- R8: Complement (kind 11) returns the bitwise inverse of the first operand. Logical NOT (kind 12) returns 1 when the first operand is zero and 0 otherwise.
- R9: Sign extension (kind 13) fills bits 63 down to W with bit W-1 of the first operand, for width codes 0, 1 and 2. Width code 3 returns the operand unchanged.
- R10: When use_imm_i is 1, imm_i replaces b_i as the second operand for every kind, and b_i has no effect.
- R11: The result appears on res_o one clock after its inputs are applied. While rst_n is low, res_o is 0.
- R12: op_i[5:2] carries the kind code and op_i[1:0] carries the width code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits). Kinds 14 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 6 | Kind code in bits 5:2, width code in bits 1:0 |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand (register form) |
| imm_i | input | 64 | Second operand (immediate form) |
| use_imm_i | input | 1 | Selects imm_i instead of b_i |
| res_o | output | 64 | Registered result |

## Verification
The only state in the block is the result register, so a fault in a width lane or in the result select appears on res_o one cycle after the inputs that trigger it. The corner cases that expose such faults are the ones that cross a width boundary: a shift amount equal to or larger than the width, a carry or borrow out of the top bit of a narrow lane, a sign bit inside a narrow field, and upper operand bits that must not leak into a narrow result. The compare cases include operands whose signed and unsigned ordering disagree, which catches a swapped signedness select on the very next result.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int KIND_W = 4;
    localparam int WCODE_W = 2;

    localparam logic [KIND_W-1:0] K_ADD  = 4'd0;
    localparam logic [KIND_W-1:0] K_SUB  = 4'd1;
    localparam logic [KIND_W-1:0] K_MUL  = 4'd2;
    localparam logic [KIND_W-1:0] K_SHL  = 4'd3;
    localparam logic [KIND_W-1:0] K_SHR  = 4'd4;
    localparam logic [KIND_W-1:0] K_SRA  = 4'd5;
    localparam logic [KIND_W-1:0] K_AND  = 4'd6;
    localparam logic [KIND_W-1:0] K_OR   = 4'd7;
    localparam logic [KIND_W-1:0] K_XOR  = 4'd8;
    localparam logic [KIND_W-1:0] K_CMPU = 4'd9;
    localparam logic [KIND_W-1:0] K_CMPS = 4'd10;
    localparam logic [KIND_W-1:0] K_CPL  = 4'd11;
    localparam logic [KIND_W-1:0] K_LNOT = 4'd12;
    localparam logic [KIND_W-1:0] K_SEXT = 4'd13;

endpackage

// File: rtl/int_width_lane.sv
module int_width_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] add_o,
    output logic [W-1:0] sub_o,
    output logic [W-1:0] mul_o,
    output logic [W-1:0] shl_o,
    output logic [W-1:0] shr_o,
    output logic [W-1:0] sra_o
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] shamt;

    always_comb begin
        shamt = b_i[SW-1:0];
        add_o = a_i + b_i;
        sub_o = a_i - b_i;
        mul_o = a_i * b_i;
        shl_o = a_i << shamt;
        shr_o = a_i >> shamt;
        sra_o = W'($signed(a_i) >>> shamt);
    end
endmodule

// File: rtl/int_cmp3.sv
module int_cmp3 #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            signed_i,
    output logic [XLEN-1:0] res_o
);
    logic lt;
    logic eq;

    always_comb begin
        eq = (a_i == b_i);
        if (signed_i) begin
            lt = $signed(a_i) < $signed(b_i);
        end else begin
            lt = a_i < b_i;
        end
        if (eq) begin
            res_o = '0;
        end else if (lt) begin
            res_o = '1;
        end else begin
            res_o = XLEN'(1);
        end
    end
endmodule

// File: rtl/int_unary.sv
module int_unary #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [1:0]      wcode_i,
    output logic [XLEN-1:0] cpl_o,
    output logic [XLEN-1:0] lnot_o,
    output logic [XLEN-1:0] sext_o
);
    always_comb begin
        cpl_o  = ~a_i;
        lnot_o = XLEN'(a_i == '0);
        case (wcode_i)
            2'd0:    sext_o = XLEN'($signed(a_i[7:0]));
            2'd1:    sext_o = XLEN'($signed(a_i[15:0]));
            2'd2:    sext_o = XLEN'($signed(a_i[31:0]));
            default: sext_o = a_i;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [5:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [XLEN-1:0] imm_i,
    input  logic            use_imm_i,
    output logic [XLEN-1:0] res_o
);
    localparam int NW = $clog2(XLEN / 8) + 1;

    typedef struct packed {
        logic [XLEN-1:0] res;
    } exec_state_t;

    exec_state_t st_d, st_q;

    logic [KIND_W-1:0]  kind;
    logic [WCODE_W-1:0] wcode;
    logic [WCODE_W-1:0] lane_sel;
    logic [XLEN-1:0]    b_eff;

    logic [XLEN-1:0] l_add [NW];
    logic [XLEN-1:0] l_sub [NW];
    logic [XLEN-1:0] l_mul [NW];
    logic [XLEN-1:0] l_shl [NW];
    logic [XLEN-1:0] l_shr [NW];
    logic [XLEN-1:0] l_sra [NW];

    logic [XLEN-1:0] cmp_res;
    logic [XLEN-1:0] cpl_res;
    logic [XLEN-1:0] lnot_res;
    logic [XLEN-1:0] sext_res;

    assign kind  = op_i[5:2];
    assign wcode = op_i[1:0];
    assign b_eff = use_imm_i ? imm_i : b_i;
    assign lane_sel = (int'(wcode) >= NW) ? WCODE_W'(NW - 1) : wcode;

    for (genvar gi = 0; gi < NW; gi++) begin : g_lane
        localparam int LW = 8 << gi;
        logic [LW-1:0] add_w, sub_w, mul_w, shl_w, shr_w, sra_w;

        int_width_lane #(.W(LW)) lane_i (
            .a_i   (a_i[LW-1:0]),
            .b_i   (b_eff[LW-1:0]),
            .add_o (add_w),
            .sub_o (sub_w),
            .mul_o (mul_w),
            .shl_o (shl_w),
            .shr_o (shr_w),
            .sra_o (sra_w)
        );

        assign l_add[gi] = XLEN'(add_w);
        assign l_sub[gi] = XLEN'(sub_w);
        assign l_mul[gi] = XLEN'(mul_w);
        assign l_shl[gi] = XLEN'(shl_w);
        assign l_shr[gi] = XLEN'(shr_w);
        assign l_sra[gi] = XLEN'(sra_w);
    end

    int_cmp3 #(.XLEN(XLEN)) cmp_i (
        .a_i      (a_i),
        .b_i      (b_eff),
        .signed_i (kind == K_CMPS),
        .res_o    (cmp_res)
    );

    int_unary #(.XLEN(XLEN)) unary_i (
        .a_i     (a_i),
        .wcode_i (wcode),
        .cpl_o   (cpl_res),
        .lnot_o  (lnot_res),
        .sext_o  (sext_res)
    );

    always_comb begin
        st_d = st_q;
        case (kind)
            K_ADD:          st_d.res = l_add[lane_sel];
            K_SUB:          st_d.res = l_sub[lane_sel];
            K_MUL:          st_d.res = l_mul[lane_sel];
            K_SHL:          st_d.res = l_shl[lane_sel];
            K_SHR:          st_d.res = l_shr[lane_sel];
            K_SRA:          st_d.res = l_sra[lane_sel];
            K_AND:          st_d.res = a_i & b_eff;
            K_OR:           st_d.res = a_i | b_eff;
            K_XOR:          st_d.res = a_i ^ b_eff;
            K_CMPU, K_CMPS: st_d.res = cmp_res;
            K_CPL:          st_d.res = cpl_res;
            K_LNOT:         st_d.res = lnot_res;
            K_SEXT:         st_d.res = sext_res;
            default:        st_d.res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;

    // Marks that one input set has been registered since reset
    logic chk_vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_vld_q <= 1'b0;
        end else begin
            chk_vld_q <= 1'b1;
        end
    end

    p_reset_zero_r11: assert property (@(posedge clk)
        !rst_n |-> res_o == '0);

    // R1..R5: byte-width lane results leave the upper bits clear
    p_narrow_zext_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_q && $past(op_i[5:2]) <= K_SRA && $past(op_i[1:0]) == 2'd0)
        |-> res_o[XLEN-1:8] == '0);

    p_cmp_ternary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_q && ($past(op_i[5:2]) == K_CMPU || $past(op_i[5:2]) == K_CMPS))
        |-> (res_o == '0 || res_o == XLEN'(1) || res_o == '1));

    p_lnot_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_q && $past(op_i[5:2]) == K_LNOT)
        |-> (res_o[XLEN-1:1] == '0 && res_o[0] == ($past(a_i) == '0)));

    p_and_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_q && $past(op_i[5:2]) == K_AND)
        |-> (res_o & ~$past(a_i)) == '0);

    p_or_superset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_q && $past(op_i[5:2]) == K_OR)
        |-> (res_o & $past(a_i)) == $past(a_i));

    p_sext_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_q && $past(op_i[5:2]) == K_SEXT && $past(op_i[1:0]) == 2'd0)
        |-> (res_o[XLEN-1:7] == '0 || res_o[XLEN-1:7] == '1));

    p_unknown_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_q && $past(op_i[5:2]) > K_SEXT)
        |-> res_o == '0);
endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  op_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [63:0] imm_i = '0;
    logic        use_imm_i = 1'b0;
    logic [63:0] res_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    int_exec_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .imm_i     (imm_i),
        .use_imm_i (use_imm_i),
        .res_o     (res_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [5:0]  op;
        logic        use_imm;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] imm;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 36;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam vec_t VEC [NV] = '{
        // R1 add/sub wrap at width
        '{8'd1, 6'h00, 1'b0, 64'h1234_5678_0000_00FF, 64'h2, 64'h0, 64'h1},
        '{8'd1, 6'h03, 1'b0, ONES, 64'h1, 64'h0, 64'h0},
        '{8'd1, 6'h05, 1'b0, 64'h0, 64'h1, 64'h0, 64'hFFFF},
        '{8'd1, 6'h06, 1'b0, 64'h5, 64'h7, 64'h0, 64'hFFFF_FFFE},
        // R2 multiply low bits
        '{8'd2, 6'h08, 1'b0, 64'h10, 64'h10, 64'h0, 64'h0},
        '{8'd2, 6'h08, 1'b0, 64'h0F, 64'h11, 64'h0, 64'hFF},
        '{8'd2, 6'h0B, 1'b0, 64'h1_0000_0001, 64'h1_0000_0001, 64'h0, 64'h2_0000_0001},
        // R3 left shift, amount modulo width
        '{8'd3, 6'h0C, 1'b0, 64'h81, 64'h9, 64'h0, 64'h02},
        '{8'd3, 6'h0F, 1'b0, 64'h1, 64'h3F, 64'h0, 64'h8000_0000_0000_0000},
        '{8'd3, 6'h0F, 1'b0, 64'h1, 64'h40, 64'h0, 64'h1},
        // R4 logical right shift
        '{8'd4, 6'h11, 1'b0, 64'hFFFF_8000, 64'hF, 64'h0, 64'h1},
        // R5 arithmetic right shift
        '{8'd5, 6'h14, 1'b0, 64'h80, 64'h3, 64'h0, 64'hF0},
        '{8'd5, 6'h16, 1'b0, 64'h8000_0000, 64'h1F, 64'h0, 64'hFFFF_FFFF},
        '{8'd5, 6'h17, 1'b0, 64'h8000_0000_0000_0000, 64'h4, 64'h0, 64'hF800_0000_0000_0000},
        // R6 bitwise ops use all 64 bits
        '{8'd6, 6'h18, 1'b0, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 64'h0, 64'h0F00_0F00_0F00_0F00},
        '{8'd6, 6'h1D, 1'b0, 64'hF000_0000_0000_0000, 64'h1, 64'h0, 64'hF000_0000_0000_0001},
        '{8'd6, 6'h20, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA, ONES, 64'h0, 64'h5555_5555_5555_5555},
        // R7 three-way compare
        '{8'd7, 6'h24, 1'b0, 64'h1, ONES, 64'h0, ONES},
        '{8'd7, 6'h24, 1'b0, 64'h5, 64'h5, 64'h0, 64'h0},
        '{8'd7, 6'h24, 1'b0, ONES, 64'h1, 64'h0, 64'h1},
        '{8'd7, 6'h28, 1'b0, ONES, 64'h1, 64'h0, ONES},
        '{8'd7, 6'h28, 1'b0, 64'h1, ONES, 64'h0, 64'h1},
        // R8 complement and logical not
        '{8'd8, 6'h2C, 1'b0, 64'hF, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0},
        '{8'd8, 6'h30, 1'b0, 64'h0, 64'h0, 64'h0, 64'h1},
        '{8'd8, 6'h30, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 64'h0, 64'h0},
        // R9 sign extension
        '{8'd9, 6'h34, 1'b0, 64'h80, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FF80},
        '{8'd9, 6'h34, 1'b0, 64'h1234_567F, 64'h0, 64'h0, 64'h7F},
        '{8'd9, 6'h35, 1'b0, 64'h8001, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_8001},
        '{8'd9, 6'h36, 1'b0, 64'hAB00_0000_7FFF_FFFF, 64'h0, 64'h0, 64'h7FFF_FFFF},
        '{8'd9, 6'h36, 1'b0, 64'h8000_0000, 64'h0, 64'h0, 64'hFFFF_FFFF_8000_0000},
        '{8'd9, 6'h37, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0, 64'h0, 64'h0123_4567_89AB_CDEF},
        // R10 immediate replaces b_i
        '{8'd10, 6'h03, 1'b1, 64'hA, 64'h64, 64'h5, 64'hF},
        '{8'd10, 6'h0F, 1'b1, 64'h1, 64'h0, 64'h4, 64'h10},
        '{8'd10, 6'h24, 1'b1, 64'h3, 64'h3, 64'h9, ONES},
        // R12 unused kinds
        '{8'd12, 6'h38, 1'b0, 64'hFFFF, 64'h1, 64'h0, 64'h0},
        '{8'd12, 6'h3C, 1'b0, ONES, ONES, 64'h0, 64'h0}
    };

    task automatic check(input int req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: res_o=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op_i      = v.op;
        a_i       = v.a;
        b_i       = v.b;
        imm_i     = v.imm;
        use_imm_i = v.use_imm;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, res_o=%h expected=done", res_o);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset value with live inputs
        drive(VEC[16]);
        repeat (3) @(negedge clk);
        check(11, res_o, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(negedge clk);
            check(int'(VEC[i].req), res_o, VEC[i].exp);
        end

        // R11: one-cycle latency, old result held until the edge
        @(negedge clk);
        drive(VEC[6]);
        @(negedge clk);
        drive(VEC[22]);
        #1;
        check(11, res_o, VEC[6].exp);
        @(negedge clk);
        check(11, res_o, VEC[22].exp);

        // R10: b_i changes have no effect while the immediate is selected
        drive(VEC[31]);
        @(negedge clk);
        b_i = ONES;
        @(negedge clk);
        check(10, res_o, 64'hF);

        // R11: reset in mid-stream clears the result
        rst_n = 1'b0;
        #1;
        check(11, res_o, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(VEC[1]);
        @(negedge clk);
        check(11, res_o, 64'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule